// File: doc/BRIEF.md
# Stack Register-Range Transfer Sequencer

This block moves a contiguous range of general registers to or from the stack, one 32-bit word per clock, through a single word-wide memory port. It supports four operations: saving a range on the stack, restoring a range from the stack, and two return forms. A return form first deallocates a stack frame by adding an immediate to the stack pointer. It can then restore a register range, and it finally loads the return address from the stack.

A caller presents the operation, the first and last register indices, the incoming stack pointer, the immediate and the instruction address, then pulses `go` for one cycle. Register values for a save are fetched through a combinational read port. Restored values leave through a write port with a valid/ready handshake, so the register file may hold off a write. The updated stack pointer stays on `spOut` after the sequence. A malformed range is rejected when `go` is sampled, and nothing is moved.

Top module: `stack_seq`

## Requirements
- R1: After reset, `done`, `pcValid`, `undefExc`, `illegalExc`, `memWrEn`, `memRdEn` and `rfWrValid` are low, and `spOut` is 0.
- R2: The operation codes on `opSel` are 0 = save range, 1 = restore range, 2 = return with range restore, 3 = return without range. For codes 0 to 2, if `firstReg` or `lastReg` is 0, `undefExc` pulses for one cycle, starting the cycle after `go`. No memory access and no register write happen, and `spOut` is unchanged.
- R3: For codes 0 to 2 with neither index 0, `firstReg >= lastReg` pulses `illegalExc` for one cycle, starting the cycle after `go`. In that cycle `pcOut` equals `instrPc`, nothing is transferred, and `spOut` is unchanged.
- R4: A save writes the registers from `lastReg` down to `firstReg`, one per cycle on consecutive cycles. Each write goes to the current stack pointer minus 4 and carries that register's value, and the pointer then drops by 4. The final `spOut` is `spIn - 4*N`, where N = lastReg - firstReg + 1.
- R5: A restore reads the word at the current stack pointer for each register from `firstReg` up to `lastReg`, in that order, and offers it as a register write. The pointer then rises by 4. The final `spOut` is `spIn + 4*N`.
- R6: While `rfWrValid` is high and `rfWrReady` is low, the write index, the data and the stack pointer hold, and the transfer does not advance.
- R7: Return with range (code 2) sets the stack pointer to `spIn + imm - 4*N`, restores the range in ascending order, and then reads the return address from the next word. `pcOut` carries that word while `pcValid` pulses for one cycle. The final pointer is `spIn + imm + 4`.
- R8: Return without range (code 3) performs no index checks. It sets the pointer to `spIn + imm`, reads the return address there, and ends with `spOut = spIn + imm + 4`.
- R9: `done` is high for exactly one cycle, the cycle after the last transfer. It does not rise for a rejected range.
- R10: `go` has no effect while a sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start strobe, sampled when idle |
| opSel | input | 2 | Operation code |
| firstReg | input | 4 | Lowest register index of the range |
| lastReg | input | 4 | Highest register index of the range |
| spIn | input | 32 | Stack pointer at start |
| imm | input | 32 | Frame deallocation amount for returns |
| instrPc | input | 32 | Address of the instruction being executed |
| rfRdIdx | output | 4 | Register file read index |
| rfRdData | input | 32 | Register file read data (combinational) |
| rfWrValid | output | 1 | Restored word offered to register file |
| rfWrReady | input | 1 | Register file accepts the write |
| rfWrIdx | output | 4 | Register file write index |
| rfWrData | output | 32 | Register file write data |
| memAddr | output | 32 | Memory word address (byte units) |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | 32 | Memory write data |
| memRdEn | output | 1 | Memory read strobe |
| memRdData | input | 32 | Memory read data, same cycle |
| spOut | output | 32 | Current stack pointer |
| pcOut | output | 32 | Return address, or instruction address on illegal range |
| pcValid | output | 1 | One-cycle pulse when a return address is loaded |
| done | output | 1 | One-cycle completion pulse |
| undefExc | output | 1 | Range touches the stack pointer register |
| illegalExc | output | 1 | Range empty or reversed |

## Verification
The assertions assume that memory answers a read in the same cycle and accepts a write in one cycle. They also assume that `rfWrReady` is a plain level the register file may drop at any time. The bench models memory as a combinational array and drives the ready input from a counter on a delay after the clock edge, so it never changes near a sampling point. Operands are held steady from `go` until the sequence ends, apart from the deliberate second `go` that checks that a start during a sequence is ignored.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  typedef enum logic [1:0] {
    OP_SAVE      = 2'd0,
    OP_RESTORE   = 2'd1,
    OP_RET_RANGE = 2'd2,
    OP_RET_ONLY  = 2'd3
  } seqOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadSpIn;
    logic loadSpRet;
    logic useRange;
    logic decSp;
    logic incSp;
    logic addrPreDec;
    logic loadPcMem;
    logic loadPcInstr;
  } dpCtrl_t;

endpackage

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
#(
  parameter int REG_IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 go,
  input  logic [1:0]           opSel,
  input  logic [REG_IDX_W-1:0] firstReg,
  input  logic [REG_IDX_W-1:0] lastReg,
  input  logic                 rfWrReady,
  output dpCtrl_t              dpCtrl,
  output logic [REG_IDX_W-1:0] curIdx,
  output logic                 memWrEn,
  output logic                 memRdEn,
  output logic                 rfWrValid,
  output logic                 done,
  output logic                 pcValid,
  output logic                 undefExc,
  output logic                 illegalExc
);

  typedef enum logic [2:0] {S_IDLE, S_SAVE, S_LOAD, S_PCLOAD, S_FIN} state_e;

  state_e                 state, stateNxt;
  logic [REG_IDX_W-1:0]   curNxt, endIdx, endNxt;
  logic                   retMode, retNxt;
  logic                   undefNxt, illegalNxt;
  logic                   touchesSp, rangeBad, needRange;

  assign touchesSp = (firstReg == '0) || (lastReg == '0);
  assign rangeBad  = (firstReg >= lastReg);
  assign needRange = (seqOp_e'(opSel) != OP_RET_ONLY);

  always_comb begin
    stateNxt   = state;
    curNxt     = curIdx;
    endNxt     = endIdx;
    retNxt     = retMode;
    undefNxt   = 1'b0;
    illegalNxt = 1'b0;
    dpCtrl     = '0;
    case (state)
      S_IDLE: if (go) begin
        if (needRange && touchesSp) begin
          undefNxt = 1'b1;
        end else if (needRange && rangeBad) begin
          illegalNxt         = 1'b1;
          dpCtrl.loadPcInstr = 1'b1;
        end else begin
          case (seqOp_e'(opSel))
            OP_SAVE: begin
              dpCtrl.loadSpIn = 1'b1;
              curNxt = lastReg;  endNxt = firstReg;
              retNxt = 1'b0;     stateNxt = S_SAVE;
            end
            OP_RESTORE: begin
              dpCtrl.loadSpIn = 1'b1;
              curNxt = firstReg; endNxt = lastReg;
              retNxt = 1'b0;     stateNxt = S_LOAD;
            end
            OP_RET_RANGE: begin
              dpCtrl.loadSpRet = 1'b1;
              dpCtrl.useRange  = 1'b1;
              curNxt = firstReg; endNxt = lastReg;
              retNxt = 1'b1;     stateNxt = S_LOAD;
            end
            default: begin
              dpCtrl.loadSpRet = 1'b1;
              stateNxt = S_PCLOAD;
            end
          endcase
        end
      end
      S_SAVE: begin
        dpCtrl.decSp      = 1'b1;
        dpCtrl.addrPreDec = 1'b1;
        if (curIdx == endIdx) stateNxt = S_FIN;
        else curNxt = curIdx - 1'b1;
      end
      S_LOAD: if (rfWrReady) begin
        dpCtrl.incSp = 1'b1;
        if (curIdx == endIdx) stateNxt = retMode ? S_PCLOAD : S_FIN;
        else curNxt = curIdx + 1'b1;
      end
      S_PCLOAD: begin
        dpCtrl.incSp     = 1'b1;
        dpCtrl.loadPcMem = 1'b1;
        stateNxt         = S_FIN;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      curIdx     <= '0;
      endIdx     <= '0;
      retMode    <= 1'b0;
      undefExc   <= 1'b0;
      illegalExc <= 1'b0;
      pcValid    <= 1'b0;
    end else begin
      state      <= stateNxt;
      curIdx     <= curNxt;
      endIdx     <= endNxt;
      retMode    <= retNxt;
      undefExc   <= undefNxt;
      illegalExc <= illegalNxt;
      pcValid    <= (state == S_PCLOAD);
    end
  end

  assign memWrEn   = (state == S_SAVE);
  assign memRdEn   = (state == S_LOAD) || (state == S_PCLOAD);
  assign rfWrValid = (state == S_LOAD);
  assign done      = (state == S_FIN);

endmodule

// File: rtl/stack_seq_dp.sv
module stack_seq_dp
  import stack_seq_pkg::*;
#(
  parameter int REG_IDX_W = 4,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtrl_t              dpCtrl,
  input  logic [REG_IDX_W-1:0] firstReg,
  input  logic [REG_IDX_W-1:0] lastReg,
  input  logic [DATA_W-1:0]    spIn,
  input  logic [DATA_W-1:0]    imm,
  input  logic [DATA_W-1:0]    instrPc,
  input  logic [DATA_W-1:0]    memRdData,
  output logic [DATA_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    spOut,
  output logic [DATA_W-1:0]    pcOut
);

  localparam int          WORD_BYTES = DATA_W / 8;
  localparam int          CNT_W      = REG_IDX_W + 1;
  localparam logic [DATA_W-1:0] STEP = DATA_W'(WORD_BYTES);

  logic [DATA_W-1:0] sp, pc, frameTop, rangeBytes;
  logic [CNT_W-1:0]  regCount;

  assign regCount   = {1'b0, lastReg} - {1'b0, firstReg} + CNT_W'(1);
  assign rangeBytes = DATA_W'(regCount) * STEP;
  assign frameTop   = spIn + imm - (dpCtrl.useRange ? rangeBytes : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp <= '0;
      pc <= '0;
    end else begin
      if (dpCtrl.loadSpIn)       sp <= spIn;
      else if (dpCtrl.loadSpRet) sp <= frameTop;
      else if (dpCtrl.decSp)     sp <= sp - STEP;
      else if (dpCtrl.incSp)     sp <= sp + STEP;
      if (dpCtrl.loadPcMem)        pc <= memRdData;
      else if (dpCtrl.loadPcInstr) pc <= instrPc;
    end
  end

  assign memAddr = dpCtrl.addrPreDec ? sp - STEP : sp;
  assign spOut   = sp;
  assign pcOut   = pc;

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int REG_IDX_W = 4,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 go,
  input  logic [1:0]           opSel,
  input  logic [REG_IDX_W-1:0] firstReg,
  input  logic [REG_IDX_W-1:0] lastReg,
  input  logic [DATA_W-1:0]    spIn,
  input  logic [DATA_W-1:0]    imm,
  input  logic [DATA_W-1:0]    instrPc,
  output logic [REG_IDX_W-1:0] rfRdIdx,
  input  logic [DATA_W-1:0]    rfRdData,
  output logic                 rfWrValid,
  input  logic                 rfWrReady,
  output logic [REG_IDX_W-1:0] rfWrIdx,
  output logic [DATA_W-1:0]    rfWrData,
  output logic [DATA_W-1:0]    memAddr,
  output logic                 memWrEn,
  output logic [DATA_W-1:0]    memWrData,
  output logic                 memRdEn,
  input  logic [DATA_W-1:0]    memRdData,
  output logic [DATA_W-1:0]    spOut,
  output logic [DATA_W-1:0]    pcOut,
  output logic                 pcValid,
  output logic                 done,
  output logic                 undefExc,
  output logic                 illegalExc
);

  dpCtrl_t              dpCtrl;
  logic [REG_IDX_W-1:0] curIdx;

  stack_seq_ctrl #(.REG_IDX_W(REG_IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .go(go), .opSel(opSel),
    .firstReg(firstReg), .lastReg(lastReg), .rfWrReady(rfWrReady),
    .dpCtrl(dpCtrl), .curIdx(curIdx), .memWrEn(memWrEn), .memRdEn(memRdEn),
    .rfWrValid(rfWrValid), .done(done), .pcValid(pcValid),
    .undefExc(undefExc), .illegalExc(illegalExc)
  );

  stack_seq_dp #(.REG_IDX_W(REG_IDX_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl),
    .firstReg(firstReg), .lastReg(lastReg), .spIn(spIn), .imm(imm),
    .instrPc(instrPc), .memRdData(memRdData),
    .memAddr(memAddr), .spOut(spOut), .pcOut(pcOut)
  );

  assign rfRdIdx   = curIdx;
  assign rfWrIdx   = curIdx;
  assign rfWrData  = memRdData;
  assign memWrData = rfRdData;

endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int REG_IDX_W = 4,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 memWrEn,
  input logic                 memRdEn,
  input logic                 rfWrValid,
  input logic                 rfWrReady,
  input logic [REG_IDX_W-1:0] rfWrIdx,
  input logic [DATA_W-1:0]    spOut,
  input logic                 pcValid,
  input logic                 done,
  input logic                 undefExc,
  input logic                 illegalExc
);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4
  save_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> spOut == $past(spOut) - DATA_W'(4));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrValid && !rfWrReady) |=> rfWrValid && $stable(rfWrIdx) && $stable(spOut));

  // R2
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (undefExc || illegalExc) |-> !memWrEn && !memRdEn && !done);

  // R7
  pc_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcValid |-> $past(memRdEn) && !$past(rfWrValid));

  // R5
  port_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memWrEn && memRdEn));

endmodule

bind stack_seq stack_seq_chk #(.REG_IDX_W(REG_IDX_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_stack_seq.sv
`timescale 1ns/1ps
module tb_stack_seq;

  localparam int PERIOD = 4;
  localparam logic [2:0] K_WR = 3'd0, K_RF = 3'd1, K_PC = 3'd2, K_DONE = 3'd3,
                         K_UNDEF = 3'd4, K_ILL = 3'd5;

  typedef struct packed { logic [2:0] kind; logic [31:0] a; logic [31:0] b; } item_t;

  logic clk = 0, rstN = 0, go = 0;
  logic [1:0] opSel = 0;
  logic [3:0] firstReg = 0, lastReg = 0;
  logic [31:0] spIn = 0, imm = 0, instrPc = 0;
  logic [3:0] rfRdIdx, rfWrIdx;
  logic [31:0] rfRdData, rfWrData, memAddr, memWrData, memRdData, spOut, pcOut;
  logic rfWrValid, rfWrReady = 1, memWrEn, memRdEn, pcValid, done, undefExc, illegalExc;

  logic [31:0] mem [0:255];
  item_t q[$];
  int checks = 0, errors = 0, cyc = 0, goCyc = 0, expSpan = 0, lastXfer = 0;
  bit stallOn = 0;
  string curReq = "R1";

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] regVal(input logic [3:0] i);
    return 32'hA500_0000 | (32'(i) * 32'h0001_0101);
  endfunction

  assign rfRdData  = regVal(rfRdIdx);
  assign memRdData = mem[memAddr[9:2]];

  stack_seq dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: compare observed events with the queue
  task automatic expectEv(input logic [2:0] kind, input logic [31:0] a, input logic [31:0] b);
    item_t it;
    if (q.size() == 0) begin
      check(0, curReq, {29'd0, kind}, 32'hFFFF_FFFF);
    end else begin
      it = q.pop_front();
      check(it.kind == kind, curReq, {29'd0, kind}, {29'd0, it.kind});
      check(it.a == a && it.b == b, curReq, a ^ b, it.a ^ it.b);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (memWrEn) begin
        expectEv(K_WR, memAddr, memWrData);
        mem[memAddr[9:2]] = memWrData;
        lastXfer = cyc;
      end
      if (rfWrValid && rfWrReady) begin
        expectEv(K_RF, 32'(rfWrIdx), rfWrData);
        lastXfer = cyc;
      end
      if (memRdEn && !rfWrValid) lastXfer = cyc;
      if (pcValid) expectEv(K_PC, pcOut, 0);
      if (done) begin
        expectEv(K_DONE, 0, 0);
        // R9: done one cycle after the last transfer
        check(cyc == lastXfer + 1, "R9", cyc, lastXfer + 1);
        if (expSpan != 0) check(cyc - goCyc == expSpan, "R4", cyc - goCyc, expSpan);
      end
      if (undefExc) expectEv(K_UNDEF, spOut, 0);
      if (illegalExc) expectEv(K_ILL, pcOut, spOut);
    end
  end

  int stallCnt = 0;
  always @(posedge clk) begin
    #1;
    stallCnt++;
    rfWrReady = !stallOn || (stallCnt % 3 == 0);
  end

  task automatic push(input logic [2:0] k, input logic [31:0] a, input logic [31:0] b);
    item_t it;
    it.kind = k; it.a = a; it.b = b;
    q.push_back(it);
  endtask

  task automatic runOp(input string req, input logic [1:0] op, input logic [3:0] f, input logic [3:0] l,
                       input logic [31:0] sp0, input logic [31:0] im, input logic [31:0] pc0,
                       input bit extraGo);
    logic [31:0] sp, prevSp;
    int n, wait_n;
    curReq = req;
    prevSp = spOut;
    n = int'(l) - int'(f) + 1;
    expSpan = 0;
    if (op != 2'd3 && (f == 0 || l == 0)) begin
      push(K_UNDEF, prevSp, 0); sp = prevSp;
    end else if (op != 2'd3 && f >= l) begin
      push(K_ILL, pc0, prevSp); sp = prevSp;
    end else if (op == 2'd0) begin
      sp = sp0;
      for (int i = int'(l); i >= int'(f); i--) begin
        sp = sp - 4; push(K_WR, sp, regVal(4'(i)));
      end
      push(K_DONE, 0, 0); expSpan = n + 1;
    end else begin
      sp = (op == 2'd1) ? sp0 : (op == 2'd2) ? sp0 + im - 32'(4 * n) : sp0 + im;
      if (op != 2'd3)
        for (int i = int'(f); i <= int'(l); i++) begin
          push(K_RF, 32'(i), mem[sp[9:2]]); sp = sp + 4;
        end
      if (op != 2'd1) begin
        push(K_PC, mem[sp[9:2]], 0); sp = sp + 4;
      end
      push(K_DONE, 0, 0);
    end
    opSel = op; firstReg = f; lastReg = l; spIn = sp0; imm = im; instrPc = pc0;
    go = 1; goCyc = cyc + 1;
    @(negedge clk); go = 0;
    if (extraGo) begin
      @(negedge clk); opSel = 2'd3; imm = 32'h40; go = 1;
      @(negedge clk); go = 0;
    end
    wait_n = 0;
    while (q.size() != 0 && wait_n < 500) begin @(negedge clk); wait_n++; end
    check(q.size() == 0, req, q.size(), 0);
    q.delete();
    repeat (3) @(negedge clk);
    check(spOut == sp, req, spOut, sp);
    check(!done && !memWrEn && !memRdEn, "R10", {memWrEn, memRdEn, done}, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hC000_0000 | 32'(i * 7);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!done && !pcValid && !undefExc && !illegalExc && !memWrEn && !memRdEn && !rfWrValid,
          "R1", {done, pcValid, undefExc, illegalExc}, 0);
    check(spOut == 0, "R1", spOut, 0);
    rstN = 1;
    @(negedge clk);

    runOp("R4", 2'd0, 4'd3, 4'd6, 32'h200, 0, 0, 0);
    stallOn = 1;
    runOp("R6", 2'd1, 4'd3, 4'd6, 32'h1F0, 0, 0, 0);
    stallOn = 0;
    runOp("R5", 2'd1, 4'd1, 4'd4, 32'h80, 0, 0, 0);
    runOp("R10", 2'd0, 4'd1, 4'd2, 32'h300, 0, 0, 1);
    runOp("R4", 2'd0, 4'd1, 4'd15, 32'h3F0, 0, 0, 0);
    runOp("R2", 2'd0, 4'd0, 4'd5, 32'h100, 0, 32'h10, 0);
    runOp("R2", 2'd1, 4'd4, 4'd0, 32'h100, 0, 32'h14, 0);
    runOp("R2", 2'd2, 4'd0, 4'd3, 32'h100, 32'h8, 32'h18, 0);
    runOp("R3", 2'd0, 4'd5, 4'd5, 32'h100, 0, 32'h1234, 0);
    runOp("R3", 2'd1, 4'd7, 4'd2, 32'h100, 0, 32'h5678, 0);
    // frame for returns
    runOp("R4", 2'd0, 4'd4, 4'd7, 32'h100, 0, 0, 0);
    mem[32'h100 >> 2] = 32'h0000_4A20;
    stallOn = 1;
    runOp("R7", 2'd2, 4'd4, 4'd7, 32'hE0, 32'h20, 0, 0);
    stallOn = 0;
    mem[32'h140 >> 2] = 32'h0000_7F10;
    runOp("R8", 2'd3, 4'd0, 4'd0, 32'h80, 32'hC0, 0, 0);
    runOp("R8", 2'd3, 4'd9, 4'd2, 32'h100, 32'h40, 0, 0);
    summary();
  end

endmodule